// File: doc/BRIEF.md
# Serial Code-Memory Programming Engine

This block is a slave engine that takes commands over a three-wire serial link and programs an on-chip code-memory array. It is used while the device is held in programming mode. `sck` and `mosi` are brought into the system clock domain through synchronisers, and edges are found there. Every command is four bytes long. The engine answers on `miso`, shifting the answer out during the bytes that carry read data.

Nothing the engine receives has any effect until a key command has completed and returned its echo byte. After that the engine can:
- erase the whole array,
- read or write single bytes,
- stream whole 256-byte pages in or out,
- set three protection levels and read them back,
- read identification bytes.

Write and erase time is modelled with busy timers counted in system clocks. While a write is busy, a read of the address just written returns that byte with its top bit inverted. Software can poll this to see when the write has finished.

Top module: `isp_cmd_engine`

## Requirements
- R1: A command is four bytes, most significant bit first. `mosi` is taken on each rising `sck` edge. `miso` changes only after a falling `sck` edge or when the link is idle. The answer byte for a byte slot is driven starting at the falling edge that follows the last rising edge of the previous byte.
- R2: After `prog_mode` rises, `sck` must stay low for QUIET_CLKS system clocks before any edge counts. Edges that come earlier are ignored and restart the quiet window.
- R3: The enable command is bytes 0xAC, 0x53, any, any. It returns 0x69 in the fourth byte slot. Until it has completed after `prog_mode` rises, every other command is ignored and every read slot returns 0x00.
- R4: Chip erase is 0xAC followed by a byte of the form 100x_xxxx. It is busy for ERASE_BUSY_CLKS clocks, reads 0x00 throughout, and leaves every location at 0xFF. It also clears all three lock bits.
- R5: Byte read uses opcode 0x20 and byte write uses opcode 0x40. The address is the low nibble of byte 2 (address bits 11..8) followed by byte 3 (bits 7..0). Byte 4 is the data returned or written.
- R6: A byte write holds the engine busy for WRITE_BUSY_CLKS clocks. Byte writes issued while busy are ignored. During that time, a read of the last written address returns the written byte with bit 7 inverted. Reads of other addresses return normal data.
- R7: Page read (0x30) and page write (0x50) take one byte whose low nibble selects the page, followed by exactly 256 data bytes for offsets 0 to 255. The byte after the last data byte is decoded as a new command.
- R8: Lock write is 0xAC followed by 1110_00ba, where the code {b,a} of 01, 10 or 11 sets lock bit 1, 2 or 3. A level is only taken if the level below it is already set. Lock read (0x24) returns lock bit 1 in bit 2, lock bit 2 in bit 3 and lock bit 3 in bit 4, with all other bits 0.
- R9: With lock bit 1 set, byte and page writes are ignored until the next chip erase.
- R10: With lock bit 2 set, memory reads and signature reads return 0x00.
- R11: Signature read (0x28) returns SIG_BYTE0, SIG_BYTE1 or SIG_BYTE2 for index 0, 1 or 2 in bits 1..0 of byte 3. Any other index returns 0x00.
- R12: After reset, `miso` is 0, the engine is not enabled and no lock bit is set.
- R13: Dropping `prog_mode` aborts any partial command and clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | High while the device is in programming mode |
| sck | input | 1 | Serial shift clock, asynchronous to `clk` |
| mosi | input | 1 | Serial command and data input |
| miso | output | 1 | Serial answer output, registered |

## Verification
The bench goes after these corner cases:
- **Early shifting.** Shifting starts before the quiet window has passed. An engine that did not hold off would decode garbage instead of staying silent.
- **Commands before the key.** Commands sent before the enable key must be ignored. An engine that let them through would write memory.
- **Read timing.** Reads fall during an erase and during a write. A wrong ordering of the busy, poll and lock checks would return stored data instead of 0x00 or the polled byte.
- **Page framing.** A full page is streamed in and then out, followed by a plain byte read. An off-by-one in the page counter would misplace data or swallow the following command.
- **Lock sequencing.** Protection levels are set out of order and then cleared by an erase. These tests catch a lock engine that skips a level or survives the erase.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_SPECIAL = 8'hAC;
  localparam logic [7:0] OP_RD_BYTE = 8'h20;
  localparam logic [7:0] OP_WR_BYTE = 8'h40;
  localparam logic [7:0] OP_RD_PAGE = 8'h30;
  localparam logic [7:0] OP_WR_PAGE = 8'h50;
  localparam logic [7:0] OP_RD_LOCK = 8'h24;
  localparam logic [7:0] OP_RD_SIG  = 8'h28;
  localparam logic [7:0] ENABLE_KEY  = 8'h53;
  localparam logic [7:0] ENABLE_ECHO = 8'h69;
  localparam logic [2:0] ERASE_TAG   = 3'b100;
  localparam logic [5:0] LOCK_TAG    = 6'b111000;

  typedef enum logic [1:0] {
    SLOT_OP   = 2'd0,
    SLOT_HI   = 2'd1,
    SLOT_LO   = 2'd2,
    SLOT_DATA = 2'd3
  } slot_t;
endpackage

// File: rtl/isp_serial_link.sv
module isp_serial_link #(
  parameter int SYNC_STAGES = 2,
  parameter int QUIET_CLKS  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       sck_pin,
  input  logic       mosi_pin,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       miso
);
  localparam int QW = $clog2(QUIET_CLKS + 1);

  logic [SYNC_STAGES-1:0] sck_sync, mosi_sync;
  logic sck_s, mosi_s, sck_d, rise, fall, ready;
  logic [QW-1:0] quiet_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sr, tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync  <= '0;
      mosi_sync <= '0;
      sck_d     <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_pin};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_pin};
      sck_d     <= sck_s;
    end
  end

  assign sck_s  = sck_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;

  // quiet window: SCK low for QUIET_CLKS clocks before the link listens
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      quiet_cnt <= '0;
      ready     <= 1'b0;
    end else if (!ready) begin
      if (sck_s)
        quiet_cnt <= '0;
      else if (quiet_cnt == QW'(QUIET_CLKS - 1))
        ready <= 1'b1;
      else
        quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ready) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      miso     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        rx_sr   <= {rx_sr[6:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sr[6:0], mosi_s};
        end
      end
      if (fall) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_byte[7];
          tx_sr <= {tx_byte[6:0], 1'b0};
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (miso != $past(miso)) |-> $past(fall || !ready)); // R1
  AST_READY_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(!sck_s)); // R2
endmodule

// File: rtl/isp_code_mem.sv
module isp_code_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/isp_write_ctrl.sv
module isp_write_ctrl #(
  parameter int DEPTH           = 1024,
  parameter int AW              = $clog2(DEPTH),
  parameter int WRITE_BUSY_CLKS = 2000,
  parameter int ERASE_BUSY_CLKS = 3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          erase_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          wr_busy,
  output logic          er_busy
);
  localparam int ERASE_CLKS = (ERASE_BUSY_CLKS > DEPTH) ? ERASE_BUSY_CLKS : DEPTH;
  localparam int MAX_CLKS   = (ERASE_CLKS > WRITE_BUSY_CLKS) ? ERASE_CLKS : WRITE_BUSY_CLKS;
  localparam int CW         = $clog2(MAX_CLKS + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] sweep;
  logic          sweep_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sweep     <= '0;
      sweep_on  <= 1'b0;
      wr_busy   <= 1'b0;
      er_busy   <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (er_busy) begin
        if (sweep_on) begin
          mem_we    <= 1'b1;
          mem_waddr <= sweep;
          mem_wdata <= 8'hFF;
          sweep     <= sweep + 1'b1;
          if (sweep == AW'(DEPTH - 1))
            sweep_on <= 1'b0;
        end
        if (cnt == CW'(1))
          er_busy <= 1'b0;
        cnt <= cnt - 1'b1;
      end else if (erase_req) begin
        er_busy  <= 1'b1;
        wr_busy  <= 1'b0;
        cnt      <= CW'(ERASE_CLKS);
        sweep    <= '0;
        sweep_on <= 1'b1;
      end else if (wr_req) begin
        mem_we    <= 1'b1;
        mem_waddr <= wr_addr;
        mem_wdata <= wr_data;
        wr_busy   <= 1'b1;
        cnt       <= CW'(WRITE_BUSY_CLKS);
      end else if (wr_busy) begin
        if (cnt == CW'(1))
          wr_busy <= 1'b0;
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_ERASE_FILLS_ONES: assert property (@(posedge clk) disable iff (rst)
    (er_busy && mem_we) |-> (mem_wdata == 8'hFF)); // R4
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(wr_busy && er_busy)); // R4
  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(wr_req)); // R6
endmodule

// File: rtl/isp_cmd_engine.sv
module isp_cmd_engine
  import isp_pkg::*;
#(
  parameter int         MEM_DEPTH       = 1024,
  parameter int         WRITE_BUSY_CLKS = 2000,
  parameter int         ERASE_BUSY_CLKS = 3000,
  parameter int         QUIET_CLKS      = 64,
  parameter int         SYNC_STAGES     = 2,
  parameter logic [7:0] SIG_BYTE0       = 8'hA5,
  parameter logic [7:0] SIG_BYTE1       = 8'h3C,
  parameter logic [7:0] SIG_BYTE2       = 8'h07
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_DEPTH);

  logic          rx_valid;
  logic [7:0]    rx_byte, tx_q;
  logic          mem_we, wr_busy, er_busy;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [7:0]    mem_wdata, rd_data;
  logic          wr_req, erase_req;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  logic          enabled, page_on, page_wr;
  slot_t         slot;
  logic [7:0]    b1, b2, b3, page_cnt;
  logic [3:0]    page_hi;
  logic          lb1, lb2, lb3;
  logic [AW-1:0] last_addr;
  logic [7:0]    last_data;
  logic [1:0]    pend;
  logic [7:0]    mem_view, sig_view;
  logic [11:0]   hdr_addr, exe_addr, page_addr, page_next;

  isp_serial_link #(.SYNC_STAGES(SYNC_STAGES), .QUIET_CLKS(QUIET_CLKS)) link_i (
    .clk(clk), .rst(rst), .active(prog_mode), .sck_pin(sck), .mosi_pin(mosi),
    .tx_byte(tx_q), .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso));

  isp_write_ctrl #(.DEPTH(MEM_DEPTH), .AW(AW), .WRITE_BUSY_CLKS(WRITE_BUSY_CLKS),
                   .ERASE_BUSY_CLKS(ERASE_BUSY_CLKS)) wctl_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_req(erase_req), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .wr_busy(wr_busy), .er_busy(er_busy));

  isp_code_mem #(.DEPTH(MEM_DEPTH), .AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data));

  assign hdr_addr  = {b2[3:0], rx_byte};
  assign exe_addr  = {b2[3:0], b3};
  assign page_addr = {page_hi, page_cnt};
  assign page_next = {page_hi, page_cnt + 8'd1};

  // answer for a memory read: erase, then protection, then poll, then data
  always_comb begin
    if (er_busy)
      mem_view = 8'h00;
    else if (lb2)
      mem_view = 8'h00;
    else if (wr_busy && (rd_addr == last_addr))
      mem_view = {~last_data[7], last_data[6:0]};
    else
      mem_view = rd_data;
  end

  always_comb begin
    if (lb2)
      sig_view = 8'h00;
    else begin
      case (rx_byte[1:0])
        2'd0:    sig_view = SIG_BYTE0;
        2'd1:    sig_view = SIG_BYTE1;
        2'd2:    sig_view = SIG_BYTE2;
        default: sig_view = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled   <= 1'b0;
      slot      <= SLOT_OP;
      page_on   <= 1'b0;
      page_wr   <= 1'b0;
      page_cnt  <= '0;
      page_hi   <= '0;
      b1        <= '0;
      b2        <= '0;
      b3        <= '0;
      lb1       <= 1'b0;
      lb2       <= 1'b0;
      lb3       <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
      pend      <= '0;
      tx_q      <= '0;
      rd_addr   <= '0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      erase_req <= 1'b0;
    end else begin
      wr_req    <= 1'b0;
      erase_req <= 1'b0;
      pend      <= {pend[0], 1'b0};
      if (pend[1])
        tx_q <= mem_view;
      if (!prog_mode) begin
        enabled <= 1'b0;
        slot    <= SLOT_OP;
        page_on <= 1'b0;
        pend    <= '0;
        tx_q    <= '0;
      end else if (rx_valid) begin
        if (page_on) begin
          page_cnt <= page_cnt + 8'd1;
          if (page_wr && !lb1 && !er_busy) begin
            wr_req    <= 1'b1;
            wr_addr   <= page_addr[AW-1:0];
            wr_data   <= rx_byte;
            last_addr <= page_addr[AW-1:0];
            last_data <= rx_byte;
          end
          if (page_cnt == 8'hFF) begin
            page_on <= 1'b0;
            tx_q    <= '0;
          end else if (!page_wr) begin
            rd_addr <= page_next[AW-1:0];
            pend    <= 2'b01;
          end
        end else begin
          case (slot)
            SLOT_OP: begin
              b1   <= rx_byte;
              tx_q <= '0;
              slot <= SLOT_HI;
            end
            SLOT_HI: begin
              b2   <= rx_byte;
              tx_q <= '0;
              if (enabled && (b1 == OP_RD_PAGE || b1 == OP_WR_PAGE)) begin
                page_on  <= 1'b1;
                page_wr  <= (b1 == OP_WR_PAGE);
                page_hi  <= rx_byte[3:0];
                page_cnt <= '0;
                slot     <= SLOT_OP;
                if (b1 == OP_RD_PAGE) begin
                  rd_addr <= AW'({rx_byte[3:0], 8'h00});
                  pend    <= 2'b01;
                end
              end else begin
                slot <= SLOT_LO;
              end
            end
            SLOT_LO: begin
              b3   <= rx_byte;
              slot <= SLOT_DATA;
              tx_q <= '0;
              if (b1 == OP_SPECIAL && b2 == ENABLE_KEY)
                tx_q <= ENABLE_ECHO;
              else if (enabled) begin
                case (b1)
                  OP_RD_BYTE: begin
                    rd_addr <= hdr_addr[AW-1:0];
                    pend    <= 2'b01;
                  end
                  OP_RD_LOCK: tx_q <= {3'b000, lb3, lb2, lb1, 2'b00};
                  OP_RD_SIG:  tx_q <= sig_view;
                  default:    tx_q <= '0;
                endcase
              end
            end
            default: begin
              slot <= SLOT_OP;
              tx_q <= '0;
              if (b1 == OP_SPECIAL && b2 == ENABLE_KEY)
                enabled <= 1'b1;
              else if (enabled) begin
                if (b1 == OP_SPECIAL && b2[7:5] == ERASE_TAG) begin
                  if (!er_busy) begin
                    erase_req <= 1'b1;
                    lb1       <= 1'b0;
                    lb2       <= 1'b0;
                    lb3       <= 1'b0;
                  end
                end else if (b1 == OP_SPECIAL && b2[7:2] == LOCK_TAG) begin
                  case (b2[1:0])
                    2'b01:   lb1 <= 1'b1;
                    2'b10:   if (lb1) lb2 <= 1'b1;
                    2'b11:   if (lb2) lb3 <= 1'b1;
                    default: ;
                  endcase
                end else if (b1 == OP_WR_BYTE) begin
                  if (!lb1 && !wr_busy && !er_busy) begin
                    wr_req    <= 1'b1;
                    wr_addr   <= exe_addr[AW-1:0];
                    wr_data   <= rx_byte;
                    last_addr <= exe_addr[AW-1:0];
                    last_data <= rx_byte;
                  end
                end
              end
            end
          endcase
        end
      end
    end
  end

  AST_MEM_CHANGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_req || erase_req) |-> enabled); // R3
  AST_ERASE_CLEARS_LOCKS: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> (!lb1 && !lb2 && !lb3)); // R4
  AST_PAGE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(page_on) && $past(prog_mode)) |-> ($past(page_cnt) == 8'hFF)); // R7
  AST_LOCK2_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(lb2) |-> lb1); // R8
  AST_LOCK3_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(lb3) |-> lb2); // R8
  AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !lb1); // R9
endmodule

// File: tb/isp_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module isp_cmd_engine_tb_top;
  localparam int HALF    = 9;
  localparam int WR_WAIT = 2100;
  localparam int ER_WAIT = 3200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_mode = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  isp_cmd_engine dut_i (.clk(clk), .rst(rst), .prog_mode(prog_mode),
                        .sck(sck), .mosi(mosi), .miso(miso));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      idle(HALF);
      rx[i] = miso;
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] c3,
                     input logic [7:0] c4, output logic [7:0] r4);
    logic [7:0] r;
    xfer(c1, r);
    xfer(c2, r);
    xfer(c3, r);
    xfer(c4, r4);
  endtask

  task automatic enter_mode();
    prog_mode = 1'b0;
    idle(10);
    prog_mode = 1'b1;
    idle(100);
  endtask

  task automatic t_reset();
    chk("R12 miso after reset", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_quiet_and_enable();
    logic [7:0] r;
    prog_mode = 1'b1;
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R2 early shifting ignored", r, 8'h00);
    idle(100);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R3 enable echo", r, 8'h69);
  endtask

  task automatic t_erase();
    logic [7:0] r;
    cmd(8'hAC, 8'h80, 8'h00, 8'h00, r);
    cmd(8'h20, 8'h00, 8'h00, 8'h00, r);
    chk("R4 read during erase", r, 8'h00);
    idle(ER_WAIT);
    cmd(8'h20, 8'h00, 8'h00, 8'h00, r);
    chk("R4 erased first", r, 8'hFF);
    cmd(8'h20, 8'h03, 8'hFF, 8'h00, r);
    chk("R4 erased last", r, 8'hFF);
  endtask

  task automatic t_gate();
    logic [7:0] r;
    xfer(8'h20, r);
    xfer(8'h00, r);
    enter_mode();
    cmd(8'h40, 8'h00, 8'h05, 8'h5A, r);
    cmd(8'h20, 8'h00, 8'h05, 8'h00, r);
    chk("R3 read before enable", r, 8'h00);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R13 realigned after abort", r, 8'h69);
    cmd(8'h20, 8'h00, 8'h05, 8'h00, r);
    chk("R3 write before enable ignored", r, 8'hFF);
  endtask

  task automatic t_byte_rw();
    logic [7:0] r;
    cmd(8'h40, 8'h03, 8'hA5, 8'hC3, r);
    cmd(8'h20, 8'h03, 8'hA5, 8'h00, r);
    chk("R6 poll inverts msb", r, 8'h43);
    cmd(8'h20, 8'h03, 8'hA4, 8'h00, r);
    chk("R6 other address during busy", r, 8'hFF);
    cmd(8'h40, 8'h03, 8'hA4, 8'h11, r);
    idle(WR_WAIT);
    cmd(8'h20, 8'h03, 8'hA5, 8'h00, r);
    chk("R5 byte read back", r, 8'hC3);
    cmd(8'h20, 8'h03, 8'hA4, 8'h00, r);
    chk("R6 write while busy ignored", r, 8'hFF);
  endtask

  task automatic t_page();
    logic [7:0] r;
    int bad;
    bad = 0;
    xfer(8'h50, r);
    xfer(8'h02, r);
    for (int i = 0; i < 256; i++) xfer(8'(i) ^ 8'h96, r);
    idle(WR_WAIT);
    xfer(8'h30, r);
    xfer(8'h02, r);
    for (int i = 0; i < 256; i++) begin
      xfer(8'h00, r);
      if (r !== (8'(i) ^ 8'h96)) bad++;
    end
    chk("R7 page mismatches", 8'(bad), 8'h00);
    cmd(8'h20, 8'h02, 8'hFF, 8'h00, r);
    chk("R7 command after page", r, 8'h69);
    cmd(8'h20, 8'h01, 8'hFF, 8'h00, r);
    chk("R7 no spill below page", r, 8'hFF);
  endtask

  task automatic t_signature();
    logic [7:0] r;
    cmd(8'h28, 8'h00, 8'h00, 8'h00, r);
    chk("R11 signature 0", r, 8'hA5);
    cmd(8'h28, 8'h00, 8'h01, 8'h00, r);
    chk("R11 signature 1", r, 8'h3C);
    cmd(8'h28, 8'h00, 8'h02, 8'h00, r);
    chk("R11 signature 2", r, 8'h07);
  endtask

  task automatic t_locks();
    logic [7:0] r;
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R12 locks clear", r, 8'h00);
    cmd(8'hAC, 8'hE2, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R8 level 2 needs level 1", r, 8'h00);
    cmd(8'hAC, 8'hE1, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R8 lock 1 in bit 2", r, 8'h04);
    cmd(8'h40, 8'h00, 8'h20, 8'h77, r);
    idle(20);
    cmd(8'h20, 8'h00, 8'h20, 8'h00, r);
    chk("R9 write blocked", r, 8'hFF);
    cmd(8'hAC, 8'hE2, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R8 lock 2 in bit 3", r, 8'h0C);
    cmd(8'h20, 8'h03, 8'hA5, 8'h00, r);
    chk("R10 read hidden", r, 8'h00);
    cmd(8'h28, 8'h00, 8'h00, 8'h00, r);
    chk("R10 signature hidden", r, 8'h00);
    cmd(8'hAC, 8'hE3, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R8 lock 3 in bit 4", r, 8'h1C);
    cmd(8'hAC, 8'h80, 8'h00, 8'h00, r);
    idle(ER_WAIT);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    chk("R4 erase clears locks", r, 8'h00);
    cmd(8'h20, 8'h03, 8'hA5, 8'h00, r);
    chk("R4 data erased", r, 8'hFF);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_quiet_and_enable();
    t_erase();
    t_gate();
    t_byte_rw();
    t_page();
    t_signature();
    t_locks();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (195000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule